// File: doc/BRIEF.md
# System Clock and Reset Controller

This block holds one 8-bit control word that software writes over a plain write-strobe bus and reads back on a read-data bus. From that word it derives the clock enable for a small microcontroller subsystem. The enable pulses once every 1, 2, 4 or 8 clock cycles. A power-management input slows the enable by a further factor of 256 and raises an output pin that tells external logic this mode is active. The same word carries a clock-stop request, a self-clearing soft reset of the CPU core and its peripherals, and a permission bit that lets a hub enter suspend.

A stopped subsystem is woken by an external wake input, which clears the stop request. A soft reset also clears the stop request. The control word is only cleared by the chip-level reset, never by the soft reset it issues. That chip-level reset is asynchronous, active-low, and released synchronously inside the block.

Top module: `sysclk_ctrl`

## Requirements
- R1: After chip reset the control word reads 0x00, `stop_o`, `core_rst_o`, `suspend_ok_o` and `pm_pin_o` are 0, and `clk_en_o` is high in every cycle.
- R2: Bits 4..0 of `bus_rdata` return the stored fields: suspend permit at bit 0, divider select at bits 2..1, stop at bit 3, core reset at bit 4. Bits 7..5 always read 0, and writes to them have no effect.
- R3: Divider select 00, 01, 10 and 11 make `clk_en_o` a one-cycle pulse every 1, 2, 4 and 8 cycles respectively.
- R4: A new divider select takes effect only after the period already in progress has completed in full. Writing divide-by-1 two cycles after a divide-by-8 pulse gives a gap of 8 cycles and then a gap of 1 cycle.
- R5: `suspend_ok_o` equals stored bit 0 in every cycle.
- R6: While the stop bit (bit 3) is set, `stop_o` is 1 and `clk_en_o` stays 0 in every cycle.
- R7: `wake_i` high during a cycle clears the stop bit at the next edge. `clk_en_o` is then high in the first cycle that has `stop_o` at 0.
- R8: Writing 1 to bit 4 drives `core_rst_o` high for exactly 4 cycles, starting in the cycle after the write. Bit 4 reads 1 during that time and returns to 0 on its own. A 1 written to bit 4 while the reset is running has no effect.
- R9: In every cycle where `core_rst_o` is high, `stop_o` is 0. A write of 1 to bit 3 that lands during those cycles is discarded. A single write that sets both bit 3 and bit 4 leaves stop at 0.
- R10: `pm_pin_o` follows `pm_mode_i` one cycle later. While it is 1, `clk_en_o` pulses once every 256 base-divider pulses: 256 cycles at divide-by-1 and 512 cycles at divide-by-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Chip reset, asynchronous, active-low |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read-back of the control word |
| wake_i | input | 1 | Wake request; clears the stop bit |
| pm_mode_i | input | 1 | Power-management mode request |
| clk_en_o | output | 1 | Divided clock enable for the subsystem |
| pm_pin_o | output | 1 | High while power-management mode is active |
| stop_o | output | 1 | Clock-stop state |
| core_rst_o | output | 1 | Soft reset to the core and peripherals |
| suspend_ok_o | output | 1 | Hub suspend permission |

## Verification
The checker enforces the following in every cycle:
- reserved bits read 0;
- suspend permission follows bit 0;
- no enable is issued while stopped;
- a wake request always leaves the stop state at the next edge;
- a soft reset keeps the stop state clear;
- the core reset pulse lasts exactly four cycles;
- the enable in power-management mode is never issued on two cycles in a row.

Only the bench scenarios can show the exact enable periods for each divider select and for the power-management mode. The same holds for the boundary-aligned divider change, for the enable resuming in the first cycle after a wake, and for the discarding of stop writes during a soft reset.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  localparam int DATA_W    = 8;
  localparam int DIV_SEL_W = 2;
  // widest divided period is 2**(2**DIV_SEL_W - 1), its counter needs this many bits
  localparam int DIV_CNT_W = (1 << DIV_SEL_W) - 1;

  // stored fields, packed so that bit 0 of the struct is bit 0 of the bus word
  typedef struct packed {
    logic                 core_rst;
    logic                 stop;
    logic [DIV_SEL_W-1:0] div_sel;
    logic                 suspend;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // last count value of a period of 2**sel cycles
  function automatic logic [DIV_CNT_W-1:0] div_last(input logic [DIV_SEL_W-1:0] sel);
    return DIV_CNT_W'((1 << sel) - 1);
  endfunction

endpackage

// File: rtl/sysclk_rst_sync.sv
module sysclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/sysclk_ctl_reg.sv
module sysclk_ctl_reg
  import sysclk_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wake,
  output ctl_t              ctl
);

  localparam int              CNT_W    = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

  ctl_t             ctl_q, ctl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ctl_d = ctl_q;
    cnt_d = cnt_q;
    if (wr) begin
      ctl_d.suspend  = wdata[0];
      ctl_d.div_sel  = wdata[DIV_SEL_W:1];
      ctl_d.stop     = wdata[DIV_SEL_W+1];
      ctl_d.core_rst = ctl_q.core_rst | wdata[DIV_SEL_W+2];
    end
    // a running soft reset counts itself out and then clears its own bit
    if (ctl_q.core_rst) begin
      if (cnt_q == CNT_LAST) begin
        ctl_d.core_rst = 1'b0;
        cnt_d          = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    // wake, or any cycle of soft reset, leaves the stop state
    if (wake || ctl_q.core_rst || ctl_d.core_rst) ctl_d.stop = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      cnt_q <= cnt_d;
    end
  end

  assign ctl = ctl_q;

endmodule

// File: rtl/sysclk_base_div.sv
module sysclk_base_div
  import sysclk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic                 stop,
  output logic                 tick
);

  logic [DIV_CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_SEL_W-1:0] act_q, act_d;
  logic                 at_end;

  assign at_end = (cnt_q == div_last(act_q));
  assign tick   = at_end && !stop;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (stop) begin
      // park on the last count so the first cycle after wake is a pulse
      cnt_d = div_last(div_sel);
      act_d = div_sel;
    end else if (at_end) begin
      cnt_d = '0;
      act_d = div_sel;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

endmodule

// File: rtl/sysclk_pm_div.sv
module sysclk_pm_div #(
  parameter int PM_DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pm_mode,
  input  logic stop,
  input  logic base_tick,
  output logic pm_pin,
  output logic en
);

  localparam int              CNT_W   = $clog2(PM_DIV);
  localparam logic [CNT_W-1:0] PM_LAST = CNT_W'(PM_DIV - 1);

  logic             pm_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign en     = base_tick && (!pm_q || (cnt_q == PM_LAST));
  assign pm_pin = pm_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!pm_q || stop)  cnt_d = PM_LAST;
    else if (base_tick) cnt_d = (cnt_q == PM_LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_q  <= 1'b0;
      cnt_q <= PM_LAST;
    end else begin
      pm_q  <= pm_mode;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int RST_CYCLES  = 4,
  parameter int PM_DIV      = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wake_i,
  input  logic              pm_mode_i,
  output logic              clk_en_o,
  output logic              pm_pin_o,
  output logic              stop_o,
  output logic              core_rst_o,
  output logic              suspend_ok_o
);

  logic rst_sn;
  ctl_t ctl;
  logic base_tick;

  sysclk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sn)
  );

  sysclk_ctl_reg #(.RST_CYCLES(RST_CYCLES)) u_ctl_reg (
    .clk   (clk),
    .rst_n (rst_sn),
    .wr    (bus_wr),
    .wdata (bus_wdata),
    .wake  (wake_i),
    .ctl   (ctl)
  );

  sysclk_base_div u_base_div (
    .clk     (clk),
    .rst_n   (rst_sn),
    .div_sel (ctl.div_sel),
    .stop    (ctl.stop),
    .tick    (base_tick)
  );

  sysclk_pm_div #(.PM_DIV(PM_DIV)) u_pm_div (
    .clk       (clk),
    .rst_n     (rst_sn),
    .pm_mode   (pm_mode_i),
    .stop      (ctl.stop),
    .base_tick (base_tick),
    .pm_pin    (pm_pin_o),
    .en        (clk_en_o)
  );

  assign bus_rdata    = {{(DATA_W-CTL_W){1'b0}}, ctl};
  assign stop_o       = ctl.stop;
  assign core_rst_o   = ctl.core_rst;
  assign suspend_ok_o = ctl.suspend;

endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk #(
  parameter int RST_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_sn,
  input logic [7:0] bus_rdata,
  input logic       wake_i,
  input logic       pm_mode_i,
  input logic       clk_en_o,
  input logic       pm_pin_o,
  input logic       stop_o,
  input logic       core_rst_o,
  input logic       suspend_ok_o
);

  localparam int RUN_LAST = RST_CYCLES - 1;

  // number of consecutive earlier cycles with core reset high
  logic [15:0] run_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)         run_q <= '0;
    else if (core_rst_o) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    bus_rdata[7:5] == 3'b000);

  a_r5_suspend_follows: assert property (@(posedge clk) disable iff (!rst_sn)
    suspend_ok_o == bus_rdata[0]);

  a_r6_stop_no_enable: assert property (@(posedge clk) disable iff (!rst_sn)
    stop_o |-> !clk_en_o);

  a_r7_wake_leaves_stop: assert property (@(posedge clk) disable iff (!rst_sn)
    wake_i |=> !stop_o);

  a_r8_rst_holds: assert property (@(posedge clk) disable iff (!rst_sn)
    (core_rst_o && (int'(run_q) < RUN_LAST)) |=> core_rst_o);

  a_r8_rst_self_clears: assert property (@(posedge clk) disable iff (!rst_sn)
    (core_rst_o && (int'(run_q) == RUN_LAST)) |=> (!core_rst_o && !bus_rdata[4]));

  a_r9_rst_clears_stop: assert property (@(posedge clk) disable iff (!rst_sn)
    core_rst_o |-> !stop_o);

  a_r10_pm_pin_follows: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(rst_sn) |-> (pm_pin_o == $past(pm_mode_i)));

  a_r10_pm_sparse: assert property (@(posedge clk) disable iff (!rst_sn)
    (pm_pin_o && clk_en_o) ##1 pm_pin_o |-> !clk_en_o);

endmodule

bind sysclk_ctrl sysclk_ctrl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk          (clk),
  .rst_sn       (rst_sn),
  .bus_rdata    (bus_rdata),
  .wake_i       (wake_i),
  .pm_mode_i    (pm_mode_i),
  .clk_en_o     (clk_en_o),
  .pm_pin_o     (pm_pin_o),
  .stop_o       (stop_o),
  .core_rst_o   (core_rst_o),
  .suspend_ok_o (suspend_ok_o)
);

// File: tb/sysclk_ctrl_bench.sv
module sysclk_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       wake_i;
  logic       pm_mode_i;
  logic       clk_en_o;
  logic       pm_pin_o;
  logic       stop_o;
  logic       core_rst_o;
  logic       suspend_ok_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sysclk_ctrl u_sysclk_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .wake_i       (wake_i),
    .pm_mode_i    (pm_mode_i),
    .clk_en_o     (clk_en_o),
    .pm_pin_o     (pm_pin_o),
    .stop_o       (stop_o),
    .core_rst_o   (core_rst_o),
    .suspend_ok_o (suspend_ok_o)
  );

  // {write data, expected read-back}; no stop or reset bits here
  localparam logic [15:0] VEC [0:6] = '{
    {8'h01, 8'h01}, {8'h02, 8'h02}, {8'h04, 8'h04}, {8'h06, 8'h06},
    {8'hE1, 8'h01}, {8'hA6, 8'h06}, {8'h00, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  // from the next enable pulse, count cycles to the following one
  task automatic gap(output int n);
    n = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (clk_en_o) break;
    end
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      n++;
      if (clk_en_o) break;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int g;
    int cnt;
    rst_n = 1'b0; bus_wr = 1'b0; bus_wdata = '0; wake_i = 1'b0; pm_mode_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 stop", stop_o, 0);
    chk("R1 core_rst", core_rst_o, 0);
    chk("R1 suspend", suspend_ok_o, 0);
    chk("R1 pm_pin", pm_pin_o, 0);
    cnt = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); cnt += int'(clk_en_o); end
    chk("R1 enable every cycle", cnt, 6);

    // R2 / R5 table walk
    for (int i = 0; i < 7; i++) begin
      bus_write(VEC[i][15:8]);
      chk("R2 read-back", bus_rdata, VEC[i][7:0]);
      chk("R5 suspend", suspend_ok_o, VEC[i][0]);
    end

    // R3 divider periods
    for (int s = 0; s < 4; s++) begin
      bus_write(8'(s << 1));
      gap(g);
      gap(g);
      chk("R3 period", g, 1 << s);
    end

    // R4 boundary change: divide-by-8, then divide-by-1 written mid-period
    bus_write(8'h06);
    gap(g);
    for (int i = 0; i < 4000; i++) begin @(negedge clk); if (clk_en_o) break; end
    cnt = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cnt++;
      if (cnt == 2) begin bus_wr = 1'b1; bus_wdata = 8'h00; end
      if (cnt == 3) bus_wr = 1'b0;
      if (clk_en_o) break;
    end
    chk("R4 old period completes", cnt, 8);
    @(negedge clk);
    chk("R4 new period", clk_en_o, 1);

    // R6 stop, R7 wake
    bus_write(8'h08);
    chk("R6 stop_o", stop_o, 1);
    chk("R6 rdata", bus_rdata, 8'h08);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); cnt += int'(clk_en_o); end
    chk("R6 no enables", cnt, 0);
    wake_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
    chk("R7 stop cleared", stop_o, 0);
    chk("R7 enable resumes", clk_en_o, 1);
    bus_write(8'h0E);
    repeat (5) @(negedge clk);
    wake_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
    chk("R7 enable resumes at div8", clk_en_o, 1);
    bus_write(8'h00);

    // R8 soft reset
    bus_write(8'h10);
    chk("R8 bit4 reads 1", bus_rdata, 8'h10);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (!core_rst_o) break;
      cnt++;
      @(negedge clk);
    end
    chk("R8 pulse length", cnt, 4);
    chk("R8 self clear", bus_rdata, 0);

    // R9 reset clears stop and drops stop writes
    bus_write(8'h18);
    chk("R9 combined write stop", stop_o, 0);
    chk("R9 core_rst active", core_rst_o, 1);
    bus_write(8'h08);
    chk("R9 stop write dropped", bus_rdata, 8'h10);
    repeat (4) @(negedge clk);
    chk("R9 after reset", bus_rdata, 0);

    // R10 power-management mode
    pm_mode_i = 1'b1;
    @(negedge clk);
    chk("R10 pm_pin", pm_pin_o, 1);
    gap(g);
    chk("R10 div1 x256", g, 256);
    bus_write(8'h02);
    gap(g);
    gap(g);
    chk("R10 div2 x256", g, 512);
    pm_mode_i = 1'b0;
    @(negedge clk);
    chk("R10 pm_pin low", pm_pin_o, 0);
    gap(g);
    gap(g);
    chk("R10 back to div2", g, 2);

    summary();
  end

endmodule